// File: doc/BRIEF.md
# EEPROM page-write controller

This block is the device-side write engine of a byte-wide non-volatile memory. It sits behind an asynchronous parallel bus with three active-low strobes (chip select, output enable and write enable), a 17-bit address and an 8-bit data path, split here into an input, an output and an output-drive flag. A fast system clock samples the strobes, the address and the data. Each write strobe loads one byte into a page buffer. The first load fixes the page. Later loads to the same page may follow, as long as each starts before a load-window timer runs out.

When the window expires, a self-timed programming cycle starts. After a fixed number of clocks it copies every loaded byte into a behavioral array in one step. While the cycle runs, new loads are ignored. Reads during that time return a status byte instead of array data: bit 7 is the inverse of bit 7 of the last loaded byte, and bit 6 flips from one read to the next. Once the cycle ends, reads return stored data again. The load window, the programming time and the minimum write pulse are parameters counted in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: A byte load is taken only while chip select and write enable are both low and output enable is high. A write strobe given with output enable low, or with chip select high, changes no array location.
- R2: The load address is the one present at the first clock sample in which the write condition holds, which is the later of the two falling strobes. The load data is the one present at the last sample in which the condition holds, which is the earlier of the two rising strobes.
- R3: One programming cycle stores up to 2^PAGE_AW bytes (256 by default). Address bits [16:8] select the page and bits [7:0] select the byte in the page.
- R4: A write condition that lasts fewer than MIN_LOW clock samples (default 3) loads nothing. One that lasts exactly MIN_LOW samples is accepted.
- R5: Programming starts once LOAD_WIN clocks have passed since the start of the latest load and no load is in progress. It lasts PROG_CYC clocks, and the array is updated when it ends.
- R6: Loads presented while programming is under way are ignored and do not reach the array.
- R7: A load in an open page whose bits [16:8] differ from the first load's is dropped. It sets page_err, which stays high until reset and is low after reset.
- R8: During programming, a read returns bit 7 as the inverse of bit 7 of the last accepted byte, and bits [5:0] equal to that byte's bits [5:0].
- R9: During programming, bit 6 of the read data inverts between successive reads. Outside programming it does not change, and reads return the array contents.
- R10: bus_drive is high only while chip select and output enable are both low. bus_dout then holds the array byte at address bits [MEM_AW-1:0] (the low 10 bits by default).
- R11: After reset every array byte reads 8'hFF and no programming cycle is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write strobe |
| bus_addr | input | 17 | Byte address |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data or status byte |
| bus_drive | output | 1 | High when bus_dout should drive the bus |
| page_err | output | 1 | Sticky flag for a dropped off-page load |

## Verification
A read that is still active when programming ends can see two sources in the same cycle: the status byte and the freshly committed array data. The bench starts a read while the cycle is running and holds output enable low across the end of the cycle, sampling the bus every clock. It checks that bit 7 changes exactly once, from the inverted value to the true value, and that the last sample equals the written byte. A second overlap is a load that arrives during the busy period. It must fall away without affecting what the commit writes.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W   = 17,
  parameter int DW       = 8,
  parameter int MEM_AW   = 10,
  parameter int PAGE_AW  = 8,
  parameter int LOAD_WIN = 16,
  parameter int PROG_CYC = 64,
  parameter int MIN_LOW  = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_din,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_drive,
  output logic              page_err
);
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PG_W  = ADDR_W - PAGE_AW;
  localparam int MP_W  = MEM_AW - PAGE_AW;
  localparam int WIN_W = $clog2(LOAD_WIN + 1) + 1;
  localparam int PRG_W = $clog2(PROG_CYC + 1);
  localparam int LO_W  = $clog2(MIN_LOW + 1) + 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_LOAD = 2'd1, S_PROG = 2'd2;

  logic [2:0]        ctl_m, ctl_q, ctl_p;
  logic [ADDR_W-1:0] a_m, a_q, a_cap;
  logic [DW-1:0]     d_m, d_q, d_p;
  logic [1:0]        st;
  logic [PG_W-1:0]   pg_q;
  logic [PAGE-1:0]   vld;
  logic [DW-1:0]     last_q;
  logic              tog;
  logic [WIN_W-1:0]  win_cnt;
  logic [PRG_W-1:0]  prog_cnt;
  logic [LO_W-1:0]   lo_cnt;
  logic [DW-1:0]     mem  [DEPTH];
  logic [DW-1:0]     pbuf [PAGE];

  wire wr_now   = ~ctl_q[2] & ~ctl_q[1] & ctl_q[0];
  wire wr_prev  = ~ctl_p[2] & ~ctl_p[1] & ctl_p[0];
  wire rd_now   = ~ctl_q[2] & ~ctl_q[0];
  wire rd_prev  = ~ctl_p[2] & ~ctl_p[0];
  wire wr_start = wr_now & ~wr_prev;
  wire wr_end   = ~wr_now & wr_prev;
  wire rd_end   = ~rd_now & rd_prev;
  wire load_ok  = wr_end && (lo_cnt >= LO_W'(MIN_LOW)) && (st != S_PROG);
  wire same_pg  = a_cap[ADDR_W-1:PAGE_AW] == pg_q;
  wire expire   = (st == S_LOAD) && (win_cnt >= WIN_W'(LOAD_WIN)) && !wr_now;
  wire prog_end = (st == S_PROG) && (prog_cnt == PRG_W'(PROG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_m <= 3'b111; ctl_q <= 3'b111; ctl_p <= 3'b111;
      a_m <= '0; a_q <= '0; d_m <= '0; d_q <= '0; d_p <= '0;
    end else begin
      ctl_m <= {chip_sel_n, wr_en_n, out_en_n};
      ctl_q <= ctl_m; ctl_p <= ctl_q;
      a_m <= bus_addr; a_q <= a_m;
      d_m <= bus_din;  d_q <= d_m; d_p <= d_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; pg_q <= '0; vld <= '0; last_q <= '0; tog <= 1'b0;
      page_err <= 1'b0; win_cnt <= '0; prog_cnt <= '0; lo_cnt <= '0; a_cap <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '1;
    end else begin
      if (wr_start) begin
        a_cap   <= a_q;
        lo_cnt  <= LO_W'(1);
        win_cnt <= '0;
      end else begin
        if (wr_now && lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
        if (win_cnt != '1) win_cnt <= win_cnt + 1'b1;
      end

      if (load_ok && (st == S_IDLE || same_pg)) begin
        pbuf[a_cap[PAGE_AW-1:0]] <= d_p;
        vld[a_cap[PAGE_AW-1:0]]  <= 1'b1;
        last_q <= d_p;
        if (st == S_IDLE) pg_q <= a_cap[ADDR_W-1:PAGE_AW];
        st <= S_LOAD;
      end else if (load_ok) begin
        page_err <= 1'b1;
      end else if (expire) begin
        st <= S_PROG;
        prog_cnt <= '0;
      end else if (st == S_PROG) begin
        prog_cnt <= prog_cnt + 1'b1;
        if (rd_end) tog <= ~tog;
        if (prog_end) begin
          for (int i = 0; i < PAGE; i++)
            if (vld[i]) mem[{pg_q[MP_W-1:0], PAGE_AW'(i)}] <= pbuf[i];
          vld <= '0;
          st  <= S_IDLE;
        end
      end
    end

  assign bus_drive = ~chip_sel_n & ~out_en_n;
  assign bus_dout  = (st == S_PROG) ? {~last_q[DW-1], tog, last_q[DW-3:0]}
                                    : mem[bus_addr[MEM_AW-1:0]];
endmodule

module eeprom_page_writer_chk #(
  parameter int PAGE_AW  = 8,
  parameter int DW       = 8,
  parameter int LOAD_WIN = 16,
  parameter int PROG_CYC = 64,
  parameter int MIN_LOW  = 3,
  parameter int WIN_W    = 6,
  parameter int PRG_W    = 7,
  parameter int LO_W     = 3
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           st,
  input logic [(1<<PAGE_AW)-1:0] vld,
  input logic [DW-1:0]        last_q,
  input logic                 tog,
  input logic                 page_err,
  input logic [WIN_W-1:0]     win_cnt,
  input logic [PRG_W-1:0]     prog_cnt,
  input logic [LO_W-1:0]      lo_cnt,
  input logic                 wr_end
);
  localparam logic [1:0] S_LOAD = 2'd1, S_PROG = 2'd2;
  logic [PRG_W:0] busy_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_run <= '0;
    else if (st == S_PROG) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;

  assert_glitch_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && lo_cnt < LO_W'(MIN_LOW) && st != S_PROG) |=> ($stable(vld) && $stable(last_q)));
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && prog_cnt != PRG_W'(PROG_CYC - 1)) |=> ($stable(vld) && $stable(last_q)));
  assert_window_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD) |=> (st != S_PROG || $past(win_cnt) >= WIN_W'(LOAD_WIN)));
  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= (PRG_W+1)'(PROG_CYC));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
  assert_toggle_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_PROG) |=> $stable(tog));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .PAGE_AW(PAGE_AW), .DW(DW), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC),
  .MIN_LOW(MIN_LOW), .WIN_W(WIN_W), .PRG_W(PRG_W), .LO_W(LO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .vld(vld), .last_q(last_q), .tog(tog),
  .page_err(page_err), .win_cnt(win_cnt), .prog_cnt(prog_cnt), .lo_cnt(lo_cnt),
  .wr_end(wr_end)
);

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 120;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        chip_sel_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic [16:0] bus_addr = '0;
  logic [7:0]  bus_din = '0;
  logic [7:0]  bus_dout;
  logic        bus_drive, page_err;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_writer u_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_drive(bus_drive), .page_err(page_err));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input int lowc,
                    input logic cs_lvl, input logic oe_lvl);
    @(negedge clk);
    bus_addr = a; bus_din = d; out_en_n = oe_lvl; chip_sel_n = cs_lvl; wr_en_n = 1'b0;
    repeat (lowc) @(negedge clk);
    wr_en_n = 1'b1;
    @(negedge clk);
    chip_sel_n = 1'b1; out_en_n = 1'b1;
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] v, output logic drv);
    @(negedge clk);
    bus_addr = a; chip_sel_n = 1'b0; out_en_n = 1'b0;
    #1 v = bus_dout; drv = bus_drive;
    @(negedge clk);
    chip_sel_n = 1'b1; out_en_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, v1, v2, prev;
    logic drv;
    int flips;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R10 idle bus not driven", bus_drive, 0);
    check("R7 err low after reset", page_err, 0);
    rd(17'h000, v, drv);
    check("R11 erased after reset", v, 8'hFF);
    check("R10 drive during read", drv, 1);

    // single byte load, strobe controlled by write enable
    wr(17'h005, 8'h3C, 4, 1'b0, 1'b1);
    settle();
    rd(17'h005, v, drv);
    check("R1 single byte stored", v, 8'h3C);

    // chip-select controlled: address at later fall, data at first rise
    @(negedge clk);
    bus_addr = 17'h1FF; bus_din = 8'h00; out_en_n = 1'b1; wr_en_n = 1'b0;
    @(negedge clk);
    bus_addr = 17'h040; bus_din = 8'hA7; chip_sel_n = 1'b0;
    repeat (4) @(negedge clk);
    chip_sel_n = 1'b1;
    @(negedge clk);
    bus_din = 8'h11; bus_addr = 17'h1FE;
    @(negedge clk);
    wr_en_n = 1'b1;
    settle();
    rd(17'h040, v, drv);
    check("R2 capture by chip select edges", v, 8'hA7);
    rd(17'h1FF, v, drv);
    check("R2 early address unused", v, 8'hFF);

    // glitch filter boundary
    wr(17'h010, 8'h77, 2, 1'b0, 1'b1);
    settle();
    rd(17'h010, v, drv);
    check("R4 short pulse ignored", v, 8'hFF);
    wr(17'h011, 8'h66, 3, 1'b0, 1'b1);
    settle();
    rd(17'h011, v, drv);
    check("R4 minimum pulse accepted", v, 8'h66);

    // inhibited strobes
    wr(17'h020, 8'h12, 4, 1'b0, 1'b0);
    settle();
    rd(17'h020, v, drv);
    check("R1 output enable low inhibits", v, 8'hFF);
    wr(17'h021, 8'h34, 4, 1'b1, 1'b1);
    settle();
    rd(17'h021, v, drv);
    check("R1 chip select high inhibits", v, 8'hFF);

    // busy status and ignored loads
    wr(17'h0C1, 8'h5A, 4, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    rd(17'h0C1, v1, drv);
    check("R8 inverted bit7", v1[7], 1);
    check("R8 low bits of last byte", v1[5:0], 6'h1A);
    rd(17'h000, v2, drv);
    check("R9 bit6 toggles", v2[6], !v1[6]);
    wr(17'h0C2, 8'h11, 4, 1'b0, 1'b1);
    settle();
    rd(17'h0C1, v1, drv);
    check("R9 true data after cycle", v1, 8'h5A);
    rd(17'h0C1, v2, drv);
    check("R9 no toggle when idle", v2, 8'h5A);
    rd(17'h0C2, v, drv);
    check("R6 busy load ignored", v, 8'hFF);

    // read held across the end of programming
    wr(17'h3F0, 8'h2B, 4, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    bus_addr = 17'h3F0; chip_sel_n = 1'b0; out_en_n = 1'b0;
    #1 prev = bus_dout;
    check("R8 status while busy", prev[7], 1);
    flips = 0;
    for (int k = 0; k < 90; k++) begin
      @(negedge clk);
      #1 if (bus_dout[7] != prev[7]) flips++;
      prev = bus_dout;
    end
    chip_sel_n = 1'b1; out_en_n = 1'b1;
    check("R9 single status-to-data change", flips, 1);
    check("R5 committed data visible", prev, 8'h2B);

    // off-page load in an open page
    wr(17'h100, 8'h01, 4, 1'b0, 1'b1);
    wr(17'h305, 8'h02, 4, 1'b0, 1'b1);
    settle();
    check("R7 err set on page mismatch", page_err, 1);
    rd(17'h100, v, drv);
    check("R3 first page byte stored", v, 8'h01);
    rd(17'h305, v, drv);
    check("R7 off-page byte dropped", v, 8'hFF);

    // full page sweep
    for (int i = 0; i < 256; i++)
      wr(17'h200 + 17'(i), 8'((i * 7 + 3) & 8'hFF), 3, 1'b0, 1'b1);
    settle();
    for (int i = 0; i < 256; i++) begin
      rd(17'h200 + 17'(i), v, drv);
      check("R3 full page byte", v, (i * 7 + 3) & 8'hFF);
    end
    rd(17'h1FF, v, drv);
    check("R3 neighbour page untouched", v, 8'hFF);
    check("R7 err stays set", page_err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule